// File: doc/BRIEF.md
# Limited-Pointer Sharer Tracker

This block holds the sharer lists of a bank of directory entries. Each entry keeps a small, fixed set of node-id pointers, not a bit per node. One command port serves four operations on a chosen entry. Add records a node that now holds a copy of the line. Remove applies a clean-eviction notice. Clear empties the entry. Query returns the nodes that must be invalidated.

A query streams its answer one node id per cycle, with a valid strobe and a last flag. The requesting node is left out of the answer. Some entries have more distinct sharers than pointers. For these, a parameter selects one of two overflow policies:

- **Recycle:** a pointer is reused and the node it named gets a forced-invalidation pulse.
- **Broadcast:** the entry switches to a conservative mode in which every node counts as a sharer.

In both cases the list may name nodes that no longer hold the line, but it never leaves out a real sharer.

Top module: `sharer_ptr_tracker`

## Requirements
- R1: After reset every entry is empty and not in broadcast mode. `cmd_ready` is high, and `inv_valid` and `fin_valid` are low.
- R2: Add (`cmd_op` = 0) puts `cmd_node` in the lowest free pointer slot of entry `cmd_entry`. A node that is already in the entry takes no second slot and triggers no overflow.
- R3: Query (`cmd_op` = 3) streams every node in the entry's target set, except the requester `cmd_node`. The nodes come out once each, in ascending id order, one per cycle on `inv_node` with `inv_valid` high. `inv_last` marks the final one. An empty target set emits nothing.
- R4: Under the recycle policy, an Add of a new node to a full entry replaces the slot at the entry's victim index. The victim index starts at slot 0 and advances by one, wrapping, after each recycle. One cycle after the command is accepted, `fin_valid` pulses with the displaced id on `fin_node`.
- R5: Under the broadcast policy, an Add of a new node to a full entry puts the entry in broadcast mode and produces no `fin_valid` pulse. A later query emits every node id from 0 to NODES-1 except the requester.
- R6: Remove (`cmd_op` = 1) frees the slot that holds `cmd_node`, so a later Add fits without overflow. Removing a node that is not in the entry has no effect.
- R7: In broadcast mode, Remove and Add leave the entry unchanged.
- R8: Clear (`cmd_op` = 2) makes every pointer invalid, leaves broadcast mode, and resets the victim index to slot 0.
- R9: `cmd_ready` is low while a query stream is in progress. A command presented during that time is not accepted.
- R10: A command changes only the entry selected by `cmd_entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | 0 add, 1 remove, 2 clear, 3 query |
| cmd_entry | input | log2(ENTRIES) | Directory entry selected |
| cmd_node | input | log2(NODES) | Sharer node for add/remove, requester for query |
| inv_valid | output | 1 | Invalidation target present |
| inv_node | output | log2(NODES) | Node id to invalidate |
| inv_last | output | 1 | Final target of the current query |
| fin_valid | output | 1 | Forced invalidation pulse (recycle policy) |
| fin_node | output | log2(NODES) | Node whose pointer was recycled |

## Verification
Two instances run side by side on the same stimulus, one per overflow policy. With fewer distinct sharers than pointers the two must give the same answer. Repeated adds of one node check that a duplicate does not fill a slot. A fifth distinct sharer splits the two policies: one gives a forced invalidation naming the first-filled node, the other gives a full broadcast list. A second overflow after a clear shows that the victim index was reset. Remove of an absent node, removes and adds on a broadcast entry, and a command held during a stream are each followed by a query, which shows whether the stored list was touched.

// File: rtl/sharer_pkg.sv
package sharer_pkg;
   typedef enum logic [1:0] {
      SH_ADD    = 2'd0,
      SH_REMOVE = 2'd1,
      SH_CLEAR  = 2'd2,
      SH_QUERY  = 2'd3
   } sh_op_e;

   localparam int OVF_RECYCLE   = 0;
   localparam int OVF_BROADCAST = 1;
endpackage

// File: rtl/sharer_slot_update.sv
module sharer_slot_update
   import sharer_pkg::*;
#(
   parameter int NODES    = 16,
   parameter int PTRS     = 4,
   parameter int OVF_MODE = OVF_RECYCLE,
   localparam int NW = $clog2(NODES),
   localparam int PW = (PTRS > 1) ? $clog2(PTRS) : 1
) (
   input  sh_op_e          op,
   input  logic [NW-1:0]   node,
   input  logic [NW-1:0]   ptr_in  [PTRS],
   input  logic [PTRS-1:0] vld_in,
   input  logic            bc_in,
   input  logic [PW-1:0]   vic_in,
   output logic [NW-1:0]   ptr_out [PTRS],
   output logic [PTRS-1:0] vld_out,
   output logic            bc_out,
   output logic [PW-1:0]   vic_out,
   output logic            fin_fire,
   output logic [NW-1:0]   fin_node
);
   logic ovf_fin;
   logic ovf_bc;

   generate
      if (OVF_MODE == OVF_BROADCAST) begin : g_bcast
         assign ovf_fin = 1'b0;
         assign ovf_bc  = 1'b1;
      end else begin : g_recycle
         assign ovf_fin = 1'b1;
         assign ovf_bc  = 1'b0;
      end
   endgenerate

   logic [PTRS-1:0] match_v;
   logic            free_any;
   logic [PW-1:0]   free_idx;
   logic [PW-1:0]   vic_inc;

   always_comb begin
      for (int i = 0; i < PTRS; i++) begin
         match_v[i] = vld_in[i] && (ptr_in[i] == node);
      end
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = PTRS - 1; i >= 0; i--) begin
         if (!vld_in[i]) begin
            free_any = 1'b1;
            free_idx = PW'(i);
         end
      end
   end

   assign vic_inc = (vic_in == PW'(PTRS - 1)) ? '0 : PW'(vic_in + PW'(1));

   always_comb begin
      ptr_out  = ptr_in;
      vld_out  = vld_in;
      bc_out   = bc_in;
      vic_out  = vic_in;
      fin_fire = 1'b0;
      fin_node = ptr_in[vic_in];
      unique case (op)
         SH_ADD: begin
            if (!bc_in && (match_v == '0)) begin
               if (free_any) begin
                  ptr_out[free_idx] = node;
                  vld_out[free_idx] = 1'b1;
               end else if (ovf_bc) begin
                  bc_out  = 1'b1;
                  vld_out = '0;
               end else begin
                  ptr_out[vic_in] = node;
                  fin_fire        = ovf_fin;
                  vic_out         = vic_inc;
               end
            end
         end
         SH_REMOVE: begin
            if (!bc_in) vld_out = vld_in & ~match_v;
         end
         SH_CLEAR: begin
            vld_out = '0;
            bc_out  = 1'b0;
            vic_out = '0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sharer_target_mask.sv
module sharer_target_mask #(
   parameter int NODES = 16,
   parameter int PTRS  = 4,
   localparam int NW = $clog2(NODES)
) (
   input  logic [NW-1:0]    ptr_in [PTRS],
   input  logic [PTRS-1:0]  vld_in,
   input  logic             bc_in,
   input  logic [NW-1:0]    req,
   output logic [NODES-1:0] mask
);
   always_comb begin
      mask = bc_in ? '1 : '0;
      for (int i = 0; i < PTRS; i++) begin
         if (vld_in[i]) mask[ptr_in[i]] = 1'b1;
      end
      mask[req] = 1'b0;
   end
endmodule

// File: rtl/sharer_inv_stream.sv
module sharer_inv_stream #(
   parameter int NODES = 16,
   localparam int NW = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NODES-1:0] load_mask,
   input  logic [NW-1:0]    load_req,
   output logic             busy,
   output logic             inv_valid,
   output logic [NW-1:0]    inv_node,
   output logic             inv_last
);
   logic [NODES-1:0] pend_q;
   logic [NODES-1:0] lowbit;
   logic [NW-1:0]    req_q;

   assign lowbit    = pend_q & (~pend_q + NODES'(1));
   assign busy      = |pend_q;
   assign inv_valid = busy;
   assign inv_last  = busy && ((pend_q & (pend_q - NODES'(1))) == '0);

   always_comb begin
      inv_node = '0;
      for (int i = 0; i < NODES; i++) begin
         if (lowbit[i]) inv_node = NW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         req_q  <= '0;
      end else if (load) begin
         pend_q <= load_mask;
         req_q  <= load_req;
      end else begin
         pend_q <= pend_q & ~lowbit;
      end
   end

   AST_SKIP_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (inv_node != req_q)) else $error("requester emitted"); // R3
   AST_ASCENDING_IDS: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_last) |=> (inv_valid && (inv_node > $past(inv_node))))
      else $error("stream order broken"); // R3
   AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy) else $error("query accepted mid-stream"); // R9
endmodule

// File: rtl/sharer_ptr_tracker.sv
module sharer_ptr_tracker
   import sharer_pkg::*;
#(
   parameter int NODES    = 16,
   parameter int PTRS     = 4,
   parameter int ENTRIES  = 8,
   parameter int OVF_MODE = OVF_RECYCLE
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   output logic                        cmd_ready,
   input  logic [1:0]                  cmd_op,
   input  logic [$clog2(ENTRIES)-1:0]  cmd_entry,
   input  logic [$clog2(NODES)-1:0]    cmd_node,
   output logic                        inv_valid,
   output logic [$clog2(NODES)-1:0]    inv_node,
   output logic                        inv_last,
   output logic                        fin_valid,
   output logic [$clog2(NODES)-1:0]    fin_node
);
   localparam int NW = $clog2(NODES);
   localparam int PW = (PTRS > 1) ? $clog2(PTRS) : 1;

   generate
      if (NODES < 2 || (NODES & (NODES - 1)) != 0) begin : g_bad_nodes
         $error("NODES must be a power of two of at least 2");
      end
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (PTRS < 1 || PTRS >= NODES) begin : g_bad_ptrs
         $error("PTRS must lie between 1 and NODES-1");
      end
      if (OVF_MODE != OVF_RECYCLE && OVF_MODE != OVF_BROADCAST) begin : g_bad_mode
         $error("OVF_MODE must select recycle or broadcast");
      end
   endgenerate

   sh_op_e op;
   logic   accept;
   logic   busy;
   assign op        = sh_op_e'(cmd_op);
   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;

   logic [NW-1:0]   ptr_q [ENTRIES][PTRS];
   logic [PTRS-1:0] vld_q [ENTRIES];
   logic            bc_q  [ENTRIES];
   logic [PW-1:0]   vic_q [ENTRIES];

   logic [NW-1:0]    sel_ptr [PTRS];
   logic [NW-1:0]    nxt_ptr [PTRS];
   logic [PTRS-1:0]  nxt_vld;
   logic             nxt_bc;
   logic [PW-1:0]    nxt_vic;
   logic             upd_fin;
   logic [NW-1:0]    upd_fin_node;
   logic [NODES-1:0] tgt_mask;

   assign sel_ptr = ptr_q[cmd_entry];

   sharer_slot_update #(
      .NODES(NODES), .PTRS(PTRS), .OVF_MODE(OVF_MODE)
   ) u_update (
      .op       (op),
      .node     (cmd_node),
      .ptr_in   (sel_ptr),
      .vld_in   (vld_q[cmd_entry]),
      .bc_in    (bc_q[cmd_entry]),
      .vic_in   (vic_q[cmd_entry]),
      .ptr_out  (nxt_ptr),
      .vld_out  (nxt_vld),
      .bc_out   (nxt_bc),
      .vic_out  (nxt_vic),
      .fin_fire (upd_fin),
      .fin_node (upd_fin_node)
   );

   sharer_target_mask #(
      .NODES(NODES), .PTRS(PTRS)
   ) u_mask (
      .ptr_in (sel_ptr),
      .vld_in (vld_q[cmd_entry]),
      .bc_in  (bc_q[cmd_entry]),
      .req    (cmd_node),
      .mask   (tgt_mask)
   );

   sharer_inv_stream #(
      .NODES(NODES)
   ) u_stream (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && (op == SH_QUERY)),
      .load_mask (tgt_mask),
      .load_req  (cmd_node),
      .busy      (busy),
      .inv_valid (inv_valid),
      .inv_node  (inv_node),
      .inv_last  (inv_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            for (int p = 0; p < PTRS; p++) ptr_q[e][p] <= '0;
            vld_q[e] <= '0;
            bc_q[e]  <= 1'b0;
            vic_q[e] <= '0;
         end
      end else if (accept && (op != SH_QUERY)) begin
         ptr_q[cmd_entry] <= nxt_ptr;
         vld_q[cmd_entry] <= nxt_vld;
         bc_q[cmd_entry]  <= nxt_bc;
         vic_q[cmd_entry] <= nxt_vic;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fin_valid <= 1'b0;
         fin_node  <= '0;
      end else begin
         fin_valid <= accept && upd_fin;
         fin_node  <= upd_fin_node;
      end
   end

   AST_FIN_FROM_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> $past(accept && (op == SH_ADD))) else $error("stray forced invalidation"); // R4
   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> $past(inv_last)) else $error("stream ended without last"); // R9
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(accept && (op == SH_CLEAR)) |->
         ((vld_q[$past(cmd_entry)] == '0) && !bc_q[$past(cmd_entry)]))
      else $error("clear left state behind"); // R8

   for (genvar e = 0; e < ENTRIES; e++) begin : g_chk_entry
      AST_BCAST_NO_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
         bc_q[e] |-> (vld_q[e] == '0)) else $error("broadcast entry holds pointers"); // R5
      for (genvar i = 0; i < PTRS; i++) begin : g_i
         for (genvar j = i + 1; j < PTRS; j++) begin : g_j
            AST_UNIQUE_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
               !(vld_q[e][i] && vld_q[e][j] && (ptr_q[e][i] == ptr_q[e][j])))
               else $error("duplicate pointer"); // R2
         end
      end
   end
endmodule

// File: tb/sharer_ptr_tracker_tb.sv
module sharer_ptr_tracker_tb;
   import sharer_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NODES = 16;
   localparam int PTRS = 4;
   localparam int ENTRIES = 8;
   localparam int NW = $clog2(NODES);
   localparam int EW = $clog2(ENTRIES);

   typedef int iq_t[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic [EW-1:0] cmd_entry = '0;
   logic [NW-1:0] cmd_node = '0;

   logic a_ready, a_iv, a_il, a_fv;
   logic [NW-1:0] a_in, a_fn;
   logic b_ready, b_iv, b_il, b_fv;
   logic [NW-1:0] b_in, b_fn;

   int n_chk = 0;
   int n_fail = 0;
   iq_t a_ids, b_ids, a_fins, b_fins;
   bit a_lasts[$];
   bit b_lasts[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sharer_ptr_tracker #(.NODES(NODES), .PTRS(PTRS), .ENTRIES(ENTRIES), .OVF_MODE(OVF_RECYCLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(a_ready), .cmd_op(cmd_op),
      .cmd_entry(cmd_entry), .cmd_node(cmd_node), .inv_valid(a_iv), .inv_node(a_in),
      .inv_last(a_il), .fin_valid(a_fv), .fin_node(a_fn));

   sharer_ptr_tracker #(.NODES(NODES), .PTRS(PTRS), .ENTRIES(ENTRIES), .OVF_MODE(OVF_BROADCAST)) u_dut_bc (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(b_ready), .cmd_op(cmd_op),
      .cmd_entry(cmd_entry), .cmd_node(cmd_node), .inv_valid(b_iv), .inv_node(b_in),
      .inv_last(b_il), .fin_valid(b_fv), .fin_node(b_fn));

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (a_iv) begin a_ids.push_back(int'(a_in)); a_lasts.push_back(a_il); end
         if (b_iv) begin b_ids.push_back(int'(b_in)); b_lasts.push_back(b_il); end
         if (a_fv) a_fins.push_back(int'(a_fn));
         if (b_fv) b_fins.push_back(int'(b_fn));
      end
   end

   function automatic string q2s(iq_t q);
      string s = "{";
      foreach (q[i]) s = {s, $sformatf(" %0d", q[i])};
      return {s, " }"};
   endfunction

   function automatic bit q_eq(iq_t x, iq_t y);
      if (x.size() != y.size()) return 1'b0;
      foreach (x[i]) if (x[i] != y[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit lasts_ok(bit l[$]);
      foreach (l[i]) if (l[i] != (i == l.size() - 1)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic iq_t all_but(int r);
      iq_t q;
      for (int n = 0; n < NODES; n++) if (n != r) q.push_back(n);
      return q;
   endfunction

   task automatic check(bit ok, string req, string what, string act, string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      a_ids.delete(); b_ids.delete(); a_lasts.delete(); b_lasts.delete();
      a_fins.delete(); b_fins.delete();
   endtask

   task automatic wait_ready();
      while (!(a_ready && b_ready)) @(negedge clk);
   endtask

   task automatic issue(sh_op_e op, int ent, int node);
      @(negedge clk);
      wait_ready();
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_entry = EW'(ent);
      cmd_node  = NW'(node);
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_ready();
   endtask

   task automatic query(string req, int ent, int node, iq_t ea, iq_t eb);
      clear_logs();
      issue(SH_QUERY, ent, node);
      check(q_eq(a_ids, ea), req, $sformatf("recycle list e%0d", ent), q2s(a_ids), q2s(ea));
      check(q_eq(b_ids, eb), req, $sformatf("broadcast list e%0d", ent), q2s(b_ids), q2s(eb));
      check(lasts_ok(a_lasts) && lasts_ok(b_lasts), "R3", "last flag placement",
            $sformatf("%0d/%0d flags", a_lasts.size(), b_lasts.size()), "only final set");
   endtask

   task automatic fin_chk(string req, iq_t ea, iq_t eb);
      check(q_eq(a_fins, ea), req, "recycle forced inval", q2s(a_fins), q2s(ea));
      check(q_eq(b_fins, eb), req, "broadcast forced inval", q2s(b_fins), q2s(eb));
   endtask

   iq_t none;

   task automatic t_reset();
      check(a_ready && b_ready && !a_iv && !b_iv && !a_fv && !b_fv, "R1", "idle outputs",
            $sformatf("rdy %0b%0b iv %0b%0b fv %0b%0b", a_ready, b_ready, a_iv, b_iv, a_fv, b_fv),
            "rdy 11 iv 00 fv 00");
      query("R1", 0, 0, none, none);
   endtask

   task automatic t_add_basic();
      clear_logs();
      issue(SH_ADD, 1, 3);
      issue(SH_ADD, 1, 7);
      fin_chk("R2", none, none);
      query("R2", 1, 0, {3, 7}, {3, 7});
      query("R3", 1, 7, {3}, {3});
   endtask

   task automatic t_duplicate();
      clear_logs();
      issue(SH_ADD, 2, 5);
      issue(SH_ADD, 2, 5);
      issue(SH_ADD, 2, 6);
      issue(SH_ADD, 2, 7);
      issue(SH_ADD, 2, 8);
      fin_chk("R2", none, none);
      query("R2", 2, 0, {5, 6, 7, 8}, {5, 6, 7, 8});
   endtask

   task automatic t_overflow();
      clear_logs();
      issue(SH_ADD, 3, 1);
      issue(SH_ADD, 3, 2);
      issue(SH_ADD, 3, 3);
      issue(SH_ADD, 3, 4);
      issue(SH_ADD, 3, 9);
      fin_chk("R4", {1}, none);
      query("R5", 3, 0, {2, 3, 4, 9}, all_but(0));
      clear_logs();
      issue(SH_ADD, 3, 10);
      fin_chk("R4", {2}, none);
      query("R4", 3, 5, {3, 4, 9, 10}, all_but(5));
   endtask

   task automatic t_remove();
      clear_logs();
      issue(SH_ADD, 4, 2);
      issue(SH_ADD, 4, 4);
      issue(SH_ADD, 4, 6);
      issue(SH_REMOVE, 4, 4);
      issue(SH_REMOVE, 4, 11);
      issue(SH_ADD, 4, 8);
      issue(SH_ADD, 4, 10);
      fin_chk("R6", none, none);
      query("R6", 4, 0, {2, 6, 8, 10}, {2, 6, 8, 10});
   endtask

   task automatic t_bcast_ignore();
      issue(SH_REMOVE, 3, 9);
      issue(SH_REMOVE, 3, 1);
      query("R7", 3, 0, {3, 4, 10}, all_but(0));
   endtask

   task automatic t_busy();
      clear_logs();
      @(negedge clk);
      wait_ready();
      cmd_valid = 1'b1; cmd_op = SH_QUERY; cmd_entry = EW'(2); cmd_node = NW'(0);
      @(negedge clk);
      check(!a_ready && !b_ready, "R9", "ready during stream",
            $sformatf("%0b%0b", a_ready, b_ready), "00");
      cmd_op = SH_CLEAR;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_ready();
      check(q_eq(a_ids, {5, 6, 7, 8}) && q_eq(b_ids, {5, 6, 7, 8}), "R9", "stream while held",
            {q2s(a_ids), q2s(b_ids)}, "{ 5 6 7 8 } twice");
      query("R9", 2, 0, {5, 6, 7, 8}, {5, 6, 7, 8});
   endtask

   task automatic t_clear();
      issue(SH_CLEAR, 3, 0);
      query("R8", 3, 0, none, none);
      issue(SH_ADD, 3, 12);
      query("R8", 3, 0, {12}, {12});
      clear_logs();
      issue(SH_ADD, 3, 13);
      issue(SH_ADD, 3, 14);
      issue(SH_ADD, 3, 15);
      issue(SH_ADD, 3, 1);
      fin_chk("R8", {12}, none);
      query("R8", 3, 0, {1, 13, 14, 15}, all_but(0));
   endtask

   task automatic t_independent();
      query("R10", 1, 0, {3, 7}, {3, 7});
      query("R10", 2, 5, {6, 7, 8}, {6, 7, 8});
      query("R10", 4, 2, {6, 8, 10}, {6, 8, 10});
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add_basic();
      t_duplicate();
      t_overflow();
      t_remove();
      t_bcast_ignore();
      t_busy();
      t_clear();
      t_independent();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule